// File: doc/BRIEF.md
# Serial Bit-Clock Generator

This block produces the bit-timing strobes for one serial channel. It has two lanes, one for transmit and one for receive. Each lane is started and stopped on its own and keeps its own phase. A transmit lane gives one shift strobe per bit, on the falling edge of its clock. A receive lane gives one sample strobe per bit, on the rising edge of its clock. The shifters, parity logic, status and interrupts sit outside the block and consume these two strobes.

The time base is chosen by a 2-bit mode. There are three internal sources, driven by a divider off the system clock: asynchronous with 16 sub-ticks per bit, asynchronous with the clock driven out on a pin, and synchronous with the clock driven out on a pin. The fourth source is an external clock pin divided by 16. In the external mode each lane counts pin edges on its own 4-bit counter. The receive lane fires half a bit after the transmit lane, so it samples mid-bit.

Each lane is a three-state machine: `LANE_IDLE`, `LANE_LOW` and `LANE_HIGH`. The clock level is high in `LANE_IDLE` and in `LANE_HIGH`.

Transitions:
- **start-internal**: `LANE_IDLE` to `LANE_LOW`. The phase is loaded with 0.
- **start-external**: `LANE_IDLE` to `LANE_HIGH`. The phase is loaded with 15.
- **tick-rise**: `LANE_LOW` to `LANE_HIGH`. The phase reaches its half-way value.
- **tick-fall**: `LANE_HIGH` to `LANE_LOW`. The phase wraps to 0.
- **stop**: `LANE_LOW` or `LANE_HIGH` to `LANE_IDLE`.

Top module: `bitclk_gen`

## Requirements
- R1: After reset both strobes are 0, `sclk_o` is 1 and `sclk_oe_o` is 0, and both lanes are idle.
- R2: `mode_i` is encoded as follows:
  - 2'b00: internal asynchronous.
  - 2'b01: internal asynchronous with clock output.
  - 2'b10: internal synchronous with clock output.
  - 2'b11: external asynchronous.

  `mode_i` and `div_i` are sampled on every cycle in which both lanes are idle. Changes to them while either lane runs have no effect on timing.
- R3: In an internal asynchronous mode, `tx_stb_o` is high in the cycle after the start request is registered. It then repeats every 16×div cycles.
- R4: In an internal asynchronous mode, `rx_stb_o` first fires 8×div cycles after the receive start is registered. It then repeats every 16×div cycles. It does not fire at the start.
- R5: Starting one lane never moves the phase of the other lane. A start request to a lane that is already running is ignored.
- R6: In synchronous mode (2'b10) the bit period is 2×div cycles. The transmit clock is low for the first div cycles and high for the next div cycles, and `tx_stb_o` fires on each fall.
- R7: `sclk_oe_o` is 1 only in modes 2'b01 and 2'b10. While it is 0, `sclk_o` is 1.
  - In mode 2'b10, `sclk_o` follows the transmit clock.
  - In mode 2'b01, `sclk_o` follows the transmit clock while that lane runs. Otherwise it follows the receive clock.
- R8: In mode 2'b11, each rising edge of `ext_clk_i` advances both running lanes' 4-bit counters. The edge passes through a two-flop synchroniser first. A started lane's counter begins at 15.
  - `tx_stb_o` fires when the transmit counter reaches 0, which is on edges 1, 17, 33 and so on.
  - `rx_stb_o` fires when the receive counter reaches 8, which is on edges 9, 25 and so on.
  - Without edges, neither strobe fires.
- R9: A stop request idles its lane at the next clock edge, and its strobe stays 0 from then on. The idle clock level is high. A stop wins over a start in the same cycle.
- R10: A divider value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Base-clock cycles per sub-tick |
| mode_i | input | 2 | Clock source select (R2) |
| tx_start_i | input | 1 | Start the transmit lane |
| tx_stop_i | input | 1 | Stop the transmit lane |
| rx_start_i | input | 1 | Start the receive lane |
| rx_stop_i | input | 1 | Stop the receive lane |
| ext_clk_i | input | 1 | External clock pin |
| tx_stb_o | output | 1 | Transmit shift strobe, one cycle per bit |
| rx_stb_o | output | 1 | Receive sample strobe, one cycle per bit |
| sclk_o | output | 1 | Serial clock pin level |
| sclk_oe_o | output | 1 | Serial clock pin drive enable |

## Verification
The internal asynchronous timing is tried with dividers of 0, 1, 2, 3 and 4. These show whether the period scales as 16×div and whether the receive strobe lands at the half-way point instead of at the start. A receive lane started four cycles into a transmit bit tells shared phase apart from per-lane phase. A second start in mid-bit tells a re-phasing start apart from an ignored one. The synchronous mode with a divider of 3 checks the pin level in each half-bit. A train of 33 external edges checks that the two counters are offset by 8 and wrap at 16.

// File: rtl/bitclk_pkg.sv
package bitclk_pkg;

    // Clock source selection; the encoding is part of the port contract.
    typedef enum logic [1:0] {
        CK_INT_ASYNC     = 2'd0,
        CK_INT_ASYNC_OUT = 2'd1,
        CK_INT_SYNC_OUT  = 2'd2,
        CK_EXT_ASYNC     = 2'd3
    } ck_mode_e;

    // Per-lane state; the clock level is high in IDLE and HIGH.
    typedef enum logic [1:0] {
        LANE_IDLE = 2'd0,
        LANE_LOW  = 2'd1,
        LANE_HIGH = 2'd2
    } lane_state_e;

    localparam int unsigned SUBTICKS = 16;
    localparam int unsigned PH_W     = $clog2(SUBTICKS);

endpackage

// File: rtl/bitclk_cfg.sv
module bitclk_cfg
    import bitclk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [1:0]       mode_i,
    output logic [DIV_W-1:0] div_o,
    output ck_mode_e         mode_o
);

    localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(1);

    // Configuration is only followed while every lane is idle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_o  <= DIV_MIN;
            mode_o <= CK_INT_ASYNC;
        end else if (idle_i) begin
            div_o  <= (div_i == '0) ? DIV_MIN : div_i;
            mode_o <= ck_mode_e'(mode_i);
        end
    end

endmodule

// File: rtl/bitclk_ext_edge.sv
module bitclk_ext_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_i,
    output logic rise_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // The pin level is taken as high out of reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ext_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/bitclk_lane.sv
module bitclk_lane
    import bitclk_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter bit IS_TX = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  ck_mode_e         mode_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             ext_tick_i,
    output logic             run_o,
    output logic             level_o,
    output logic             stb_o
);

    localparam logic [PH_W-1:0] PH_IDLE    = '1;
    localparam logic [PH_W-1:0] ASYNC_WRAP = PH_W'(SUBTICKS - 1);
    localparam logic [PH_W-1:0] ASYNC_HALF = PH_W'(SUBTICKS / 2);
    localparam logic [PH_W-1:0] SYNC_WRAP  = PH_W'(1);
    localparam logic [PH_W-1:0] SYNC_HALF  = PH_W'(1);

    lane_state_e      state_q, state_d;
    logic [PH_W-1:0]  ph_q, ph_d;
    logic [DIV_W-1:0] pre_q, pre_d;
    logic             stb_q;

    logic             is_ext, is_sync, pre_last, tick, edge_hit;
    logic [PH_W-1:0]  wrap, half, ph_step;

    assign is_ext   = (mode_i == CK_EXT_ASYNC);
    assign is_sync  = (mode_i == CK_INT_SYNC_OUT);
    assign wrap     = is_sync ? SYNC_WRAP : ASYNC_WRAP;
    assign half     = is_sync ? SYNC_HALF : ASYNC_HALF;
    assign pre_last = (pre_q == div_i - 1'b1);
    assign tick     = is_ext ? ext_tick_i : pre_last;
    assign ph_step  = (ph_q == wrap) ? '0 : ph_q + 1'b1;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        ph_d    = ph_q;
        pre_d   = pre_q;
        unique case (state_q)
            LANE_IDLE: begin
                if (start_i && !stop_i) begin
                    pre_d = '0;
                    if (is_ext) begin
                        ph_d    = PH_IDLE;
                        state_d = LANE_HIGH;
                    end else begin
                        ph_d    = '0;
                        state_d = LANE_LOW;
                    end
                end
            end
            LANE_LOW, LANE_HIGH: begin
                if (stop_i) begin
                    state_d = LANE_IDLE;
                    ph_d    = PH_IDLE;
                    pre_d   = '0;
                end else begin
                    if (!is_ext) begin
                        pre_d = pre_last ? '0 : pre_q + 1'b1;
                    end
                    if (tick) begin
                        ph_d    = ph_step;
                        state_d = (ph_step >= half) ? LANE_HIGH : LANE_LOW;
                    end
                end
            end
            default: begin
                state_d = LANE_IDLE;
                ph_d    = PH_IDLE;
                pre_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LANE_IDLE;
            ph_q    <= PH_IDLE;
            pre_q   <= '0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            pre_q   <= pre_d;
        end
    end

    // Each lane direction reacts to one clock edge only.
    if (IS_TX) begin : g_fall
        assign edge_hit = (state_q != LANE_LOW) && (state_d == LANE_LOW);
    end else begin : g_rise
        assign edge_hit = (state_q == LANE_LOW) && (state_d == LANE_HIGH);
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_q <= 1'b0;
        end else begin
            stb_q <= edge_hit;
        end
    end

    assign stb_o   = stb_q;
    assign run_o   = (state_q != LANE_IDLE);
    assign level_o = (state_q != LANE_LOW);

endmodule

// File: rtl/bitclk_gen.sv
module bitclk_gen
    import bitclk_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic [1:0]       mode_i,
    input  logic             tx_start_i,
    input  logic             tx_stop_i,
    input  logic             rx_start_i,
    input  logic             rx_stop_i,
    input  logic             ext_clk_i,
    output logic             tx_stb_o,
    output logic             rx_stb_o,
    output logic             sclk_o,
    output logic             sclk_oe_o
);

    localparam int LANES = 2;
    localparam int TX    = 0;
    localparam int RX    = 1;

    logic [LANES-1:0] start_v, stop_v, run_v, lvl_v, stb_v;
    logic [DIV_W-1:0] div_q;
    ck_mode_e         mode_q;
    logic             ext_rise;

    assign start_v = {rx_start_i, tx_start_i};
    assign stop_v  = {rx_stop_i, tx_stop_i};

    bitclk_cfg #(.DIV_W(DIV_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .idle_i (~|run_v),
        .div_i  (div_i),
        .mode_i (mode_i),
        .div_o  (div_q),
        .mode_o (mode_q)
    );

    bitclk_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_i  (ext_clk_i),
        .rise_o (ext_rise)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bitclk_lane #(
            .DIV_W (DIV_W),
            .IS_TX (g == TX)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .start_i    (start_v[g]),
            .stop_i     (stop_v[g]),
            .mode_i     (mode_q),
            .div_i      (div_q),
            .ext_tick_i (ext_rise),
            .run_o      (run_v[g]),
            .level_o    (lvl_v[g]),
            .stb_o      (stb_v[g])
        );
    end

    assign tx_stb_o = stb_v[TX];
    assign rx_stb_o = stb_v[RX];

    // Clock pin
    always_comb begin
        unique case (mode_q)
            CK_INT_SYNC_OUT: begin
                sclk_oe_o = 1'b1;
                sclk_o    = lvl_v[TX];
            end
            CK_INT_ASYNC_OUT: begin
                sclk_oe_o = 1'b1;
                sclk_o    = run_v[TX] ? lvl_v[TX] : lvl_v[RX];
            end
            default: begin
                sclk_oe_o = 1'b0;
                sclk_o    = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bitclk_gen_chk.sv
module bitclk_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_stop_i,
    input logic rx_stop_i,
    input logic tx_stb_o,
    input logic rx_stb_o,
    input logic sclk_o,
    input logic sclk_oe_o
);

    // R3: one transmit strobe per bit, never two cycles in a row
    a_r3_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb_o |=> !tx_stb_o);

    // R4: one receive strobe per bit, never two cycles in a row
    a_r4_rx_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stb_o |=> !rx_stb_o);

    // R9: a stopped transmit lane is silent
    a_r9_tx_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stop_i |=> !tx_stb_o);

    // R9: a stopped receive lane is silent
    a_r9_rx_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stop_i |=> !rx_stb_o);

    // R7: a driven pin is low whenever the transmit clock has just fallen
    a_r7_pin_low_on_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_stb_o && sclk_oe_o) |-> !sclk_o);

    // R7: an undriven pin idles high
    a_r7_undriven_high: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_oe_o |-> sclk_o);

endmodule

bind bitclk_gen bitclk_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_stop_i (tx_stop_i),
    .rx_stop_i (rx_stop_i),
    .tx_stb_o  (tx_stb_o),
    .rx_stb_o  (rx_stb_o),
    .sclk_o    (sclk_o),
    .sclk_oe_o (sclk_oe_o)
);

// File: tb/bitclk_gen_tb.sv
module bitclk_gen_tb;

    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div_i = 8'd1;
    logic [1:0]       mode_i = 2'd0;
    logic             tx_start_i = 1'b0, tx_stop_i = 1'b0;
    logic             rx_start_i = 1'b0, rx_stop_i = 1'b0;
    logic             ext_clk_i = 1'b0;
    logic             tx_stb_o, rx_stb_o, sclk_o, sclk_oe_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bitclk_gen #(.DIV_W(DIV_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_i      (div_i),
        .mode_i     (mode_i),
        .tx_start_i (tx_start_i),
        .tx_stop_i  (tx_stop_i),
        .rx_start_i (rx_start_i),
        .rx_stop_i  (rx_stop_i),
        .ext_clk_i  (ext_clk_i),
        .tx_stb_o   (tx_stb_o),
        .rx_stb_o   (rx_stb_o),
        .sclk_o     (sclk_o),
        .sclk_oe_o  (sclk_oe_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Pulse start/stop controls for one cycle; returns at the next negedge.
    task automatic pulse(input bit txs, input bit txp, input bit rxs, input bit rxp);
        tx_start_i = txs; tx_stop_i = txp; rx_start_i = rxs; rx_stop_i = rxp;
        @(negedge clk);
        tx_start_i = 1'b0; tx_stop_i = 1'b0; rx_start_i = 1'b0; rx_stop_i = 1'b0;
    endtask

    // Offsets (in negedges) of the first tx and rx strobe within n cycles.
    task automatic watch(input int n, output int t_at, output int r_at);
        t_at = -1; r_at = -1;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (tx_stb_o && t_at < 0) t_at = i;
            if (rx_stb_o && r_at < 0) r_at = i;
        end
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic [DIV_W-1:0] d);
        mode_i = m; div_i = d;
        repeat (2) @(negedge clk);
    endtask

    task automatic stop_all();
        pulse(1'b0, 1'b1, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        check(tx_stb_o == 1'b0, "R1 tx_stb", int'(tx_stb_o), 0);
        check(rx_stb_o == 1'b0, "R1 rx_stb", int'(rx_stb_o), 0);
        check(sclk_o == 1'b1, "R1 sclk", int'(sclk_o), 1);
        check(sclk_oe_o == 1'b0, "R1 sclk_oe", int'(sclk_oe_o), 0);
    endtask

    task automatic t_async_tx();
        int t, r;
        set_cfg(2'd0, 8'd2);
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        check(tx_stb_o == 1'b1, "R3 strobe at start", int'(tx_stb_o), 1);
        watch(32, t, r);
        check(t == 32, "R3 first period div2", t, 32);
        check(r == -1, "R5 idle rx silent", r, -1);
        watch(32, t, r);
        check(t == 32, "R3 second period div2", t, 32);
        stop_all();
    endtask

    task automatic t_async_rx();
        int t, r;
        set_cfg(2'd0, 8'd3);
        pulse(1'b0, 1'b0, 1'b1, 1'b0);
        check(rx_stb_o == 1'b0, "R4 no strobe at start", int'(rx_stb_o), 0);
        watch(24, t, r);
        check(r == 24, "R4 half bit div3", r, 24);
        check(t == -1, "R4 tx stays idle", t, -1);
        watch(48, t, r);
        check(r == 48, "R4 period div3", r, 48);
        stop_all();
    endtask

    task automatic t_phase();
        int t, r;
        set_cfg(2'd0, 8'd1);
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        pulse(1'b0, 1'b0, 1'b1, 1'b0);
        watch(11, t, r);
        check(r == 8, "R5 rx own phase", r, 8);
        check(t == 11, "R5 tx not re-phased", t, 11);
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        watch(15, t, r);
        check(t == 15, "R5 restart ignored tx", t, 15);
        check(r == 12, "R5 restart ignored rx", r, 12);
        stop_all();
    endtask

    task automatic t_divider();
        int t, r;
        set_cfg(2'd0, 8'd1);
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        div_i = 8'd4;
        watch(16, t, r);
        check(t == 16, "R2 divider held while running", t, 16);
        stop_all();
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        watch(64, t, r);
        check(t == 64, "R2 divider taken when idle", t, 64);
        stop_all();
        set_cfg(2'd0, 8'd0);
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        watch(16, t, r);
        check(t == 16, "R10 divider zero as one", t, 16);
        stop_all();
    endtask

    task automatic t_sync();
        int t, r;
        set_cfg(2'd2, 8'd3);
        check(sclk_oe_o == 1'b1, "R7 oe in sync", int'(sclk_oe_o), 1);
        check(sclk_o == 1'b1, "R7 idle pin high", int'(sclk_o), 1);
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        check(tx_stb_o == 1'b1, "R6 strobe at start", int'(tx_stb_o), 1);
        check(sclk_o == 1'b0, "R6 low half", int'(sclk_o), 0);
        watch(3, t, r);
        check(sclk_o == 1'b1, "R6 high half", int'(sclk_o), 1);
        watch(3, t, r);
        check(t == 3, "R6 period 2xdiv", t, 3);
        pulse(1'b0, 1'b1, 1'b0, 1'b0);
        check(sclk_o == 1'b1, "R9 idle high after stop", int'(sclk_o), 1);
        stop_all();
    endtask

    task automatic t_async_out();
        int t, r;
        set_cfg(2'd1, 8'd1);
        check(sclk_oe_o == 1'b1, "R7 oe in async out", int'(sclk_oe_o), 1);
        pulse(1'b0, 1'b0, 1'b1, 1'b0);
        check(sclk_o == 1'b0, "R7 pin follows rx", int'(sclk_o), 0);
        watch(8, t, r);
        check(r == 8 && sclk_o == 1'b1, "R7 rx high half", int'(sclk_o), 1);
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        check(sclk_o == 1'b0, "R7 pin follows tx", int'(sclk_o), 0);
        stop_all();
        set_cfg(2'd0, 8'd1);
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        check(sclk_oe_o == 1'b0 && sclk_o == 1'b1, "R7 undriven in mode 0",
              int'(sclk_oe_o), 0);
        stop_all();
    endtask

    task automatic t_stop();
        int t, r;
        set_cfg(2'd0, 8'd1);
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        pulse(1'b0, 1'b1, 1'b0, 1'b0);
        watch(40, t, r);
        check(t == -1, "R9 stopped tx silent", t, -1);
        pulse(1'b1, 1'b1, 1'b0, 1'b0);
        check(tx_stb_o == 1'b0, "R9 stop beats start", int'(tx_stb_o), 0);
        watch(20, t, r);
        check(t == -1, "R9 lane stayed idle", t, -1);
    endtask

    task automatic ext_pulse(output bit s_tx, output bit s_rx);
        s_tx = 1'b0; s_rx = 1'b0;
        for (int i = 0; i < 8; i++) begin
            ext_clk_i = (i < 4);
            @(negedge clk);
            if (tx_stb_o) s_tx = 1'b1;
            if (rx_stb_o) s_rx = 1'b1;
        end
    endtask

    task automatic t_ext();
        int t, r;
        int bad_tx = 0;
        int bad_rx = 0;
        bit s_tx, s_rx;
        set_cfg(2'd3, 8'd1);
        pulse(1'b1, 1'b0, 1'b1, 1'b0);
        watch(100, t, r);
        check(t == -1 && r == -1, "R8 no edges no strobes", t, -1);
        for (int e = 1; e <= 33; e++) begin
            ext_pulse(s_tx, s_rx);
            if (s_tx != (e % 16 == 1)) bad_tx++;
            if (s_rx != (e % 16 == 9)) bad_rx++;
        end
        check(bad_tx == 0, "R8 tx on counter 0", bad_tx, 0);
        check(bad_rx == 0, "R8 rx on counter 8", bad_rx, 0);
        stop_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_async_tx();
        t_async_rx();
        t_phase();
        t_divider();
        t_sync();
        t_async_out();
        t_stop();
        t_ext();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule